// File: doc/BRIEF.md
# Free-Running Timer with Output Compare and Input Capture

This block is a 16-bit up-counter that never stops running. Its clock comes either from a fixed divider of the system clock or from rising edges on an external count pin. Two compare channels, A and B, watch the counter. On a match, each channel sets a sticky flag and can drive its output pin to a programmed level. Two capture channels, B and D, copy the counter value when their input pins rise. A mode bit chains D behind B, so that D keeps the value B held before its latest capture.

Software reaches the block through a byte-wide register port. The 16-bit values go through holding latches, high byte first, so the counter reads and loads as one atomic value. Both compare registers sit at one address. A select bit in the output control register decides which of the two that address reaches. A standby input returns the output control register to its reset value.

Register map (byte addresses):

- 0x0 mode: bit 2 is the buffer mode, bits 1:0 are the clock select.
- 0x1 output control.
- 0x2 flags.
- 0x4/0x5 counter.
- 0x6/0x7 shared compare.
- 0x8/0x9 capture B.
- 0xA/0xB capture D.

For each 16-bit value the even address holds the high byte and the odd address the low byte. Bytes that do not exist read as 0.

Top module: `ftm_timer`

## Requirements
- R1: The clock-select field, mode register bits 1:0, resets to 00. The codes 00, 01 and 10 advance the counter once every 2, 8 and 32 system clocks.
- R2: Clock-select code 11 advances the counter once per rising edge of `ext_clk_pin`. The increment lands two to three system clocks after the edge. With no edge, the counter holds its value.
- R3: The counter is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R4: A read of a high byte returns that byte and latches the low byte. The next low-byte read returns the latched value, even if the counter has moved in between. A write of a high byte is held back, and the low-byte write then loads all 16 bits at once.
- R5: Buffer mode is mode bit 2. When it is 0, capture D latches the counter on a rising edge of `cap_d_pin`. When it is 1, each rising edge of `cap_b_pin` first moves the old capture-B value into capture D and then loads capture B with the counter. In buffer mode, `cap_d_pin` leaves capture D unchanged.
- R6: The output control register resets to 0xE0, and `standby` also sets it to 0xE0. Bits 7:5 ignore writes and always read as 1.
- R7: Output control bit 4 sends accesses at the shared compare address to compare A (0) or compare B (1). The bit changes nothing else about either channel.
- R8: Output control bits 3 and 2 enable pins A and B, and bits 1 and 0 give the levels that a match drives on A and B. A disabled pin reads 0. An enabled pin keeps its last level until the next match, then shows the programmed level one clock later.
- R9: Flags bit 0 and bit 1 are set by compare A and compare B matches (counter equals compare). Bit 2 is set by a capture B, and bit 3 by a capture D in non-buffer mode. Flags stay set until software writes 0 to the bit; writing 1 leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Returns output control register to 0xE0 |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| cap_b_pin | input | 1 | Capture B trigger, asynchronous |
| cap_d_pin | input | 1 | Capture D trigger, asynchronous |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after the strobe |
| bus_rvalid | output | 1 | Marks bus_rdata as valid |
| oc_a_pin | output | 1 | Compare output A |
| oc_b_pin | output | 1 | Compare output B |

## Verification
The checker relies on a few input rules. Read and write strobes never fall in the same cycle. The asynchronous pins hold each level for at least two system clocks, so the synchronizers catch every edge. Under these rules, a clock of counter advance without a load adds exactly one, and an idle clock holds the value.

The stimulus keeps every pin level for three clocks and issues one bus access per clock. Exact-value checks on the counter and on captures run with the external clock selected and its pin idle, so the counter stands still. The divider rates are checked only within a one-count window, because the divider phase at the counter load is not visible.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
  localparam int          ADDR_W   = 4;
  localparam logic [3:0]  A_MODE   = 4'h0;
  localparam logic [3:0]  A_OCTL   = 4'h1;
  localparam logic [3:0]  A_FLAG   = 4'h2;
  localparam logic [3:0]  A_CNT_H  = 4'h4;
  localparam logic [3:0]  A_CNT_L  = 4'h5;
  localparam logic [3:0]  A_CMP_H  = 4'h6;
  localparam logic [3:0]  A_CMP_L  = 4'h7;
  localparam logic [3:0]  A_CPB_H  = 4'h8;
  localparam logic [3:0]  A_CPB_L  = 4'h9;
  localparam logic [3:0]  A_CPD_H  = 4'hA;
  localparam logic [3:0]  A_CPD_L  = 4'hB;
  localparam logic [7:0]  OCTL_RST = 8'hE0;
  localparam logic [1:0]  CS_DIV2  = 2'b00;
  localparam logic [1:0]  CS_DIV8  = 2'b01;
  localparam logic [1:0]  CS_DIV32 = 2'b10;
  localparam logic [1:0]  CS_EXT   = 2'b11;
endpackage

// File: rtl/ftm_edge.sv
module ftm_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  localparam int SH_W = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_sync
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], pin[g]};
    end
    assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/ftm_prescale.sv
module ftm_prescale #(
  parameter int DIV_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cs,
  input  logic       ext_rise,
  output logic       tick
);
  import ftm_pkg::*;
  localparam logic [DIV_W-1:0] M2  = DIV_W'(1);
  localparam logic [DIV_W-1:0] M8  = DIV_W'(7);
  localparam logic [DIV_W-1:0] M32 = DIV_W'(31);

  logic [DIV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + DIV_W'(1);
  end

  always_comb begin
    unique case (cs)
      CS_DIV2:  tick = (div & M2)  == M2;
      CS_DIV8:  tick = (div & M8)  == M8;
      CS_DIV32: tick = (div & M32) == M32;
      default:  tick = ext_rise;
    endcase
  end
endmodule

// File: rtl/ftm_compare.sv
module ftm_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         oe,
  input  logic         lvl,
  output logic [W-1:0] cmp_val,
  output logic         hit,
  output logic         pin
);
  logic level_q;
  logic level_n;

  assign hit     = (cnt == cmp_val);
  assign level_n = hit ? lvl : level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '1;
      level_q <= 1'b0;
      pin     <= 1'b0;
    end else begin
      if (we) cmp_val <= wdata;
      level_q <= level_n;
      pin     <= oe ? level_n : 1'b0;
    end
  end
endmodule

// File: rtl/ftm_capture.sv
module ftm_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         buf_en,
  input  logic         ev_b,
  input  logic         ev_d,
  output logic [W-1:0] cap_b,
  output logic [W-1:0] cap_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_b <= '0;
      cap_d <= '0;
    end else begin
      if (ev_b) cap_b <= cnt;
      if (buf_en) begin
        if (ev_b) cap_d <= cap_b;
      end else if (ev_d) begin
        cap_d <= cnt;
      end
    end
  end
endmodule

// File: rtl/ftm_timer.sv
module ftm_timer #(
  parameter int W      = 16,
  parameter int DIV_W  = 5,
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       standby,
  input  logic       ext_clk_pin,
  input  logic       cap_b_pin,
  input  logic       cap_d_pin,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  output logic       oc_a_pin,
  output logic       oc_b_pin
);
  import ftm_pkg::*;
  localparam int NCH = 2;
  localparam int HB  = W - 8;

  logic [2:0]   mode;
  logic [4:0]   octl;
  logic [3:0]   flags;
  logic [W-1:0] cnt;
  logic [HB-1:0] wr_tmp;
  logic [7:0]   rd_tmp;
  logic [2:0]   rise;
  logic         tick;
  logic         cnt_load;
  logic [W-1:0] load_val;
  logic [W-1:0] cap_b, cap_d;
  logic [W-1:0] cmp_val [NCH];
  logic [NCH-1:0] hit, pin, oe, lvl, cmp_we;
  logic [3:0]   flag_set;
  logic [W-1:0] sel_cmp;

  ftm_edge #(.N(3), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin({cap_d_pin, cap_b_pin, ext_clk_pin}), .rise(rise)
  );

  ftm_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .cs(mode[1:0]), .ext_rise(rise[0]), .tick(tick)
  );

  assign load_val = {wr_tmp, bus_wdata};
  assign cnt_load = bus_wr && (bus_addr == A_CNT_L);
  assign oe       = {octl[2], octl[3]};
  assign lvl      = {octl[0], octl[1]};

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign cmp_we[c] = bus_wr && (bus_addr == A_CMP_L) && (octl[4] == c[0]);
    ftm_compare #(.W(W)) u_cmp (
      .clk(clk), .rst(rst), .cnt(cnt), .we(cmp_we[c]), .wdata(load_val),
      .oe(oe[c]), .lvl(lvl[c]), .cmp_val(cmp_val[c]), .hit(hit[c]), .pin(pin[c])
    );
  end
  assign oc_a_pin = pin[0];
  assign oc_b_pin = pin[1];
  assign sel_cmp  = octl[4] ? cmp_val[1] : cmp_val[0];

  ftm_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .cnt(cnt), .buf_en(mode[2]), .ev_b(rise[1]),
    .ev_d(rise[2]), .cap_b(cap_b), .cap_d(cap_d)
  );

  assign flag_set = {rise[2] & ~mode[2], rise[1], hit[1], hit[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode   <= '0;
      flags  <= '0;
      wr_tmp <= '0;
    end else begin
      if (cnt_load)  cnt <= load_val;
      else if (tick) cnt <= cnt + W'(1);
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata[2:0];
      if (bus_wr && (bus_addr == A_CNT_H || bus_addr == A_CMP_H))
        wr_tmp <= bus_wdata[HB-1:0];
      if (bus_wr && bus_addr == A_FLAG) flags <= (flags & bus_wdata[3:0]) | flag_set;
      else                              flags <= flags | flag_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || standby)                    octl <= OCTL_RST[4:0];
    else if (bus_wr && bus_addr == A_OCTL) octl <= bus_wdata[4:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      rd_tmp     <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          A_MODE:  bus_rdata <= {5'b0, mode};
          A_OCTL:  bus_rdata <= {OCTL_RST[7:5], octl};
          A_FLAG:  bus_rdata <= {4'b0, flags};
          A_CNT_H: begin bus_rdata <= cnt[W-1:8];     rd_tmp <= cnt[7:0];     end
          A_CMP_H: begin bus_rdata <= sel_cmp[W-1:8]; rd_tmp <= sel_cmp[7:0]; end
          A_CPB_H: begin bus_rdata <= cap_b[W-1:8];   rd_tmp <= cap_b[7:0];   end
          A_CPD_H: begin bus_rdata <= cap_d[W-1:8];   rd_tmp <= cap_d[7:0];   end
          A_CNT_L, A_CMP_L, A_CPB_L, A_CPD_L: bus_rdata <= rd_tmp;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ftm_timer_chk.sv
module ftm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         standby,
  input logic         bus_rd,
  input logic [3:0]   bus_addr,
  input logic [7:0]   bus_rdata,
  input logic         tick,
  input logic         cnt_load,
  input logic [W-1:0] cnt,
  input logic [4:0]   octl,
  input logic         oc_a_pin,
  input logic         oc_b_pin,
  input logic [2:0]   mode,
  input logic [2:0]   rise,
  input logic [W-1:0] cap_b,
  input logic [W-1:0] cap_d
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_load) |=> cnt == $past(cnt) + W'(1));
  // R2
  ext_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] == 2'b11 && !rise[0] && !cnt_load) |=> $stable(cnt));
  // R5
  buffer_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[2] && rise[1]) |=> cap_d == $past(cap_b));
  // R5
  buffer_d_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[2] && !rise[1]) |=> $stable(cap_d));
  // R6
  reserved_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'h1) |=> bus_rdata[7:5] == 3'b111);
  // R6
  standby_reset_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> octl == 5'b0);
  // R8
  pin_a_off_chk: assert property (@(posedge clk) disable iff (rst)
    !octl[3] |=> !oc_a_pin);
  // R8
  pin_b_off_chk: assert property (@(posedge clk) disable iff (rst)
    !octl[2] |=> !oc_b_pin);
endmodule

bind ftm_timer ftm_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .standby(standby), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tick(tick), .cnt_load(cnt_load), .cnt(cnt), .octl(octl),
  .oc_a_pin(oc_a_pin), .oc_b_pin(oc_b_pin), .mode(mode), .rise(rise),
  .cap_b(cap_b), .cap_d(cap_d)
);

// File: tb/ftm_timer_tb_top.sv
module ftm_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby = 1'b0;
  logic ext_clk_pin = 1'b0, cap_b_pin = 1'b0, cap_d_pin = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid, oc_a_pin, oc_b_pin;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit bypass = 0;
  logic [7:0] raw_q;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  ftm_timer dut_i (
    .clk(clk), .rst(rst), .standby(standby), .ext_clk_pin(ext_clk_pin),
    .cap_b_pin(cap_b_pin), .cap_d_pin(cap_d_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .oc_a_pin(oc_a_pin), .oc_b_pin(oc_b_pin)
  );

  // monitor: pops expected bytes as read data appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (bypass) raw_q = bus_rdata;
      else begin
        n_run++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read data act=%h exp=none", bus_rdata);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (bus_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] ah, input logic [15:0] v);
    wr(ah, v[15:8]); wr(ah + 4'd1, v[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] ah, input logic [15:0] e, input string tag);
    rd(ah, e[15:8], tag); rd(ah + 4'd1, e[7:0], tag);
  endtask

  task automatic rd16_raw(input logic [3:0] ah, output logic [15:0] v);
    bypass = 1;
    @(negedge clk); bus_addr = ah; bus_rd = 1'b1;
    @(negedge clk); bus_addr = ah + 4'd1;
    @(negedge clk); bus_rd = 1'b0; v[15:8] = raw_q;
    @(negedge clk); v[7:0] = raw_q;
    bypass = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ext_clk_pin = 1; 1: cap_b_pin = 1; default: cap_d_pin = 1; endcase
    repeat (3) @(negedge clk);
    ext_clk_pin = 0; cap_b_pin = 0; cap_d_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_pin(input logic act, input logic e, input string tag);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, e);
    end
  endtask

  task automatic chk_rate(input logic [1:0] cs, input int per);
    logic [15:0] v;
    int e;
    wr(4'h0, {6'b0, cs});
    wr16(4'h4, 16'h0000);
    repeat (256) @(negedge clk);
    rd16_raw(4'h4, v);
    e = 256 / per;
    n_run++;
    if (int'(v) < e - 1 || int'(v) > e + 1) begin
      n_fail++;
      $display("FAIL R1 rate div%0d act=%0d exp=%0d+-1", per, v, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    rd(4'h0, 8'h00, "R1 mode reset");
    rd(4'h1, 8'hE0, "R6 octl reset");
    rd(4'h2, 8'h00, "R9 flags reset");
    chk_pin(oc_a_pin, 1'b0, "R8 pin A reset");
    // R6 reserved bits and standby
    wr(4'h1, 8'h1F);
    rd(4'h1, 8'hFF, "R6 reserved read ones");
    @(negedge clk); standby = 1; @(negedge clk); standby = 0;
    rd(4'h1, 8'hE0, "R6 standby value");
    // R1 divider rates
    chk_rate(2'b00, 2);
    chk_rate(2'b01, 8);
    chk_rate(2'b10, 32);
    // R2 external counting
    wr(4'h0, 8'h03);
    wr16(4'h4, 16'h1234);
    rd16(4'h4, 16'h1234, "R2 ext idle hold");
    repeat (5) pulse(0);
    rd16(4'h4, 16'h1239, "R2 ext five edges");
    // R7 shared compare address
    wr(4'h1, 8'h00); wr16(4'h6, 16'h123B);
    wr(4'h1, 8'h10); wr16(4'h6, 16'h2000);
    rd16(4'h6, 16'h2000, "R7 select B");
    wr(4'h1, 8'h00);
    rd16(4'h6, 16'h123B, "R7 select A");
    // R8 compare output, R9 flags
    wr(4'h1, 8'h0E);
    chk_pin(oc_a_pin, 1'b0, "R8 enabled before match");
    pulse(0); pulse(0);
    chk_pin(oc_a_pin, 1'b1, "R8 match drives level");
    chk_pin(oc_b_pin, 1'b0, "R8 pin B no match");
    rd(4'h2, 8'h01, "R9 match A flag");
    pulse(0);
    chk_pin(oc_a_pin, 1'b1, "R8 level held");
    rd(4'h2, 8'h01, "R9 flag sticky");
    wr(4'h2, 8'h0E);
    rd(4'h2, 8'h00, "R9 write zero clears");
    wr(4'h1, 8'h02);
    @(negedge clk);
    chk_pin(oc_a_pin, 1'b0, "R8 disabled drives 0");
    // R5 capture D own input
    pulse(2);
    rd16(4'hA, 16'h123C, "R5 capture D direct");
    rd(4'h2, 8'h08, "R9 capture D flag");
    // R5 buffer mode
    wr(4'h0, 8'h07);
    wr16(4'h4, 16'h4000);
    pulse(1);
    rd16(4'h8, 16'h4000, "R5 buffer B first");
    rd16(4'hA, 16'h0000, "R5 buffer D old B");
    wr16(4'h4, 16'h5000);
    pulse(1);
    rd16(4'h8, 16'h5000, "R5 buffer B second");
    rd16(4'hA, 16'h4000, "R5 buffer D chained");
    pulse(2);
    rd16(4'hA, 16'h4000, "R5 D pin ignored in buffer");
    rd(4'h2, 8'h0C, "R9 capture B flag");
    // R3 wrap
    wr16(4'h4, 16'hFFFF);
    pulse(0);
    rd16(4'h4, 16'h0000, "R3 wrap to zero");
    // R4 read latch and atomic write
    wr16(4'h4, 16'h00FF);
    rd(4'h4, 8'h00, "R4 read high");
    pulse(0);
    rd(4'h5, 8'hFF, "R4 latched low");
    wr(4'h4, 8'h77);
    pulse(0);
    wr(4'h5, 8'h88);
    rd16(4'h4, 16'h7788, "R4 atomic write");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard left act=%0d exp=0", sb.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule